// File: doc/BRIEF.md
# Exhaustive-Service Crossbar Matcher

This block schedules an N×N cell switch in which every input keeps one queue per output. Once per slot it receives a bitmap of non-empty queues and a cell count for every queue. From these it produces a one-to-one pairing of inputs to outputs. Each slot runs a single request, grant and accept pass. Output-side grant pointers and input-side accept pointers rotate, so every port is served in turn.

A pair that wins arbitration is not dropped after one cell. It stays connected on later slots while its queue still holds cells, so a multi-cell packet crosses the fabric without a break. Only the ports that are not held take part in the next pass. An optional limited mode releases a pair once it has moved a set number of cells back to back. This bounds how long other queues can wait behind a long burst.

Top module: `xbar_exh_matcher`

## Requirements
- R1: While `rst_n` is low, and on the first slot after it goes high, no input is matched. All grant and accept pointers start at index 0.
- R2: A free input requests output j only when its queue for j is non-empty. The queue for input i and output j is at bit i*N+j of `voq_nonempty` and at count field i*N+j of `voq_count`, which is CNT_W bits wide. A new match is formed only on such a request.
- R3: An output with several requests grants the first requesting free input found at or after its grant pointer, searching upward with wrap-around.
- R4: An output's grant pointer moves to one past the granted input only when that grant is accepted. Otherwise it stays where it was.
- R5: An input with several grants accepts the first granting output at or after its accept pointer, searching upward with wrap-around. The accept pointer then moves to one past the accepted output.
- R6: A matched pair is presented again on the next slot while its queue count is non-zero, as long as limited mode does not release it.
- R7: A held pair is released in the slot whose count reads zero. Its input and output join arbitration in that same slot.
- R8: With `limit_en` high, a pair that has been presented on `limit_val` consecutive slots is released even if cells remain. The run counter saturates at all ones.
- R9: No two inputs are matched to the same output in any slot.
- R10: Held inputs and outputs send no requests and receive no grants. Other ports never take them.
- R11: The match is registered: the pairing computed from the inputs before a clock edge appears on `match_vld` and `match_out` after that edge. Input i's output index is at `match_out[i*OW +: OW]`, where OW = clog2(N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| voq_nonempty | input | N*N | Non-empty flag per queue, bit i*N+j |
| voq_count | input | N*N*CNT_W | Cell count per queue, field i*N+j |
| limit_en | input | 1 | Enable limited-service release |
| limit_val | input | LIM_W | Maximum consecutive slots per pair |
| match_vld | output | N | Input i is matched this slot |
| match_out | output | N*OW | Output index for each input |

## Verification
Two directed cases come first. One has two inputs contending for the same two outputs, which separates a grant pointer that advances on grant from one that advances only on accept. The other has a single long queue, which shows whether a held pair survives a slot and whether its output stays closed to other inputs. Random traffic then runs in four shapes:
- Uniform arrivals mix holds and fresh matches.
- Diagonal arrivals, where each input feeds only its own output and the next, stress the rotation of both pointers.
- A hotspot on one output, with limited mode on, shows whether the cap hands the output around.
- Limited mode under heavy uniform load tells apart a release by cap from a release by an empty queue.

// File: rtl/xbm_pkg.sv
package xbm_pkg;

    // Next position on a ring of n entries.
    function automatic int ring_next(input int v, input int n);
        return (v + 1) % n;
    endfunction

endpackage

// File: rtl/xbm_rr_pick.sv
module xbm_rr_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          pick_vld,
    output logic [IW-1:0] pick_idx
);
    always_comb begin
        pick_vld = 1'b0;
        pick_idx = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!pick_vld && req[idx]) begin
                pick_vld = 1'b1;
                pick_idx = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/xbm_hold_gate.sv
module xbm_hold_gate #(
    parameter int N     = 4,
    parameter int CNT_W = 6,
    parameter int LIM_W = 4,
    parameter int IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic               held,
    input  logic [IW-1:0]      out_idx,
    input  logic [N*CNT_W-1:0] cnt_row,
    input  logic [LIM_W-1:0]   run_len,
    input  logic               limit_en,
    input  logic [LIM_W-1:0]   limit_val,
    output logic               keep
);
    logic [CNT_W-1:0] sel_cnt;
    logic             capped;

    always_comb begin
        sel_cnt = cnt_row[int'(out_idx)*CNT_W +: CNT_W];
        capped  = limit_en && (run_len >= limit_val);
        keep    = held && (sel_cnt != '0) && !capped;
    end
endmodule

// File: rtl/xbar_exh_matcher.sv
module xbar_exh_matcher #(
    parameter int N     = 4,
    parameter int CNT_W = 6,
    parameter int LIM_W = 4,
    localparam int OW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N*N-1:0]       voq_nonempty,
    input  logic [N*N*CNT_W-1:0] voq_count,
    input  logic                 limit_en,
    input  logic [LIM_W-1:0]     limit_val,
    output logic [N-1:0]         match_vld,
    output logic [N*OW-1:0]      match_out
);
    import xbm_pkg::*;

    localparam logic [LIM_W-1:0] RUN_MAX = {LIM_W{1'b1}};

    typedef struct packed {
        logic [N-1:0]            vld;
        logic [N-1:0][OW-1:0]    mout;
        logic [N-1:0][LIM_W-1:0] run;
        logic [N-1:0][OW-1:0]    gptr;
        logic [N-1:0][OW-1:0]    aptr;
    } state_t;

    state_t st_q, st_d;

    logic [N-1:0]         keep;
    logic [N-1:0]         out_busy;
    logic [N-1:0][N-1:0]  col_req;   // [output][input]
    logic [N-1:0][N-1:0]  row_gnt;   // [input][output]
    logic [N-1:0]         gnt_vld;
    logic [N-1:0][OW-1:0] gnt_idx;
    logic [N-1:0]         acc_vld;
    logic [N-1:0][OW-1:0] acc_idx;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_port
            xbm_hold_gate #(.N(N), .CNT_W(CNT_W), .LIM_W(LIM_W), .IW(OW)) u_hold (
                .held      (st_q.vld[gi]),
                .out_idx   (st_q.mout[gi]),
                .cnt_row   (voq_count[gi*N*CNT_W +: N*CNT_W]),
                .run_len   (st_q.run[gi]),
                .limit_en  (limit_en),
                .limit_val (limit_val),
                .keep      (keep[gi])
            );
            xbm_rr_pick #(.N(N), .IW(OW)) u_grant (
                .req      (col_req[gi]),
                .ptr      (st_q.gptr[gi]),
                .pick_vld (gnt_vld[gi]),
                .pick_idx (gnt_idx[gi])
            );
            xbm_rr_pick #(.N(N), .IW(OW)) u_accept (
                .req      (row_gnt[gi]),
                .ptr      (st_q.aptr[gi]),
                .pick_vld (acc_vld[gi]),
                .pick_idx (acc_idx[gi])
            );
            assign match_out[gi*OW +: OW] = st_q.mout[gi];
        end
    endgenerate

    assign match_vld = st_q.vld;

    // Outputs taken by held pairs, then requests from free inputs to free outputs.
    always_comb begin
        out_busy = '0;
        for (int i = 0; i < N; i++)
            if (keep[i]) out_busy[int'(st_q.mout[i])] = 1'b1;
        for (int j = 0; j < N; j++)
            for (int i = 0; i < N; i++)
                col_req[j][i] = !keep[i] && !out_busy[j] && voq_nonempty[i*N + j];
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                row_gnt[i][j] = gnt_vld[j] && (int'(gnt_idx[j]) == i);
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (keep[i]) begin
                st_d.vld[i] = 1'b1;
                st_d.run[i] = (st_q.run[i] == RUN_MAX) ? RUN_MAX : st_q.run[i] + 1'b1;
            end else if (acc_vld[i]) begin
                st_d.vld[i]  = 1'b1;
                st_d.mout[i] = acc_idx[i];
                st_d.run[i]  = LIM_W'(1);
                st_d.aptr[i] = OW'(ring_next(int'(acc_idx[i]), N));
                st_d.gptr[int'(acc_idx[i])] = OW'(ring_next(i, N));
            end else begin
                st_d.vld[i]  = 1'b0;
                st_d.mout[i] = '0;
                st_d.run[i]  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [N*N-1:0]       req_past;
    logic [N*N*CNT_W-1:0] cnt_past;
    always_ff @(posedge clk) begin
        req_past <= voq_nonempty;
        cnt_past <= voq_count;
    end

    generate
        for (gi = 0; gi < N; gi++) begin : g_chk
            logic [N-1:0] owners;
            always_comb
                for (int i = 0; i < N; i++)
                    owners[i] = st_q.vld[i] && (int'(st_q.mout[i]) == gi);

            // R9
            one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(owners));

            // R2
            fresh_match_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.vld[gi] && !$past(st_q.vld[gi])) |-> req_past[gi*N + int'(st_q.mout[gi])]);

            // R6
            exh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.vld[gi] && !limit_en &&
                 voq_count[(gi*N + int'(st_q.mout[gi]))*CNT_W +: CNT_W] != '0)
                |=> (st_q.vld[gi] && st_q.mout[gi] == $past(st_q.mout[gi])));

            // R8
            limit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.vld[gi] && limit_en && st_q.run[gi] >= limit_val)
                |=> (st_q.run[gi] <= LIM_W'(1)));

            // R7
            empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.vld[gi] && $past(st_q.vld[gi]) && st_q.run[gi] > LIM_W'(1))
                |-> (cnt_past[(gi*N + int'(st_q.mout[gi]))*CNT_W +: CNT_W] != '0));
        end
    endgenerate

endmodule

// File: tb/xbar_exh_matcher_bench.sv
module xbar_exh_matcher_bench;
    localparam int N = 4, CNT_W = 6, LIM_W = 4, OW = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N*N-1:0]       voq_nonempty = '0;
    logic [N*N*CNT_W-1:0] voq_count = '0;
    logic                 limit_en = 1'b0;
    logic [LIM_W-1:0]     limit_val = '0;
    logic [N-1:0]         match_vld;
    logic [N*OW-1:0]      match_out;

    xbar_exh_matcher #(.N(N), .CNT_W(CNT_W), .LIM_W(LIM_W)) u_xbar_exh_matcher (
        .clk(clk), .rst_n(rst_n), .voq_nonempty(voq_nonempty), .voq_count(voq_count),
        .limit_en(limit_en), .limit_val(limit_val), .match_vld(match_vld), .match_out(match_out)
    );

    always #10 clk = ~clk;

    int tests = 0, fails = 0;
    bit done = 0;
    int q [N][N];
    int mv [N], mo [N], ms [N], gp [N], ap [N];
    int nv [N], no [N], ns [N], ngp [N], nap [N];
    int mode = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        for (int i = 0; i < N; i++) begin
            check(match_vld[i] == mv[i][0], tag, int'(match_vld[i]), mv[i]);
            if (mv[i] != 0)
                check(int'(match_out[i*OW +: OW]) == mo[i], tag, int'(match_out[i*OW +: OW]), mo[i]);
        end
    endtask

    task automatic serve_and_arrive();
        for (int i = 0; i < N; i++)
            if (mv[i] != 0 && q[i][mo[i]] > 0) q[i][mo[i]]--;
        for (int i = 0; i < N; i++) begin
            int d;
            if (mode == 0 || $urandom_range(99) >= 55) continue;
            case (mode)
                1: d = $urandom_range(N-1);
                2: d = (i + $urandom_range(1)) % N;
                default: d = ($urandom_range(3) == 0) ? $urandom_range(N-1) : 0;
            endcase
            if (q[i][d] < 63) q[i][d]++;
        end
    endtask

    task automatic drive();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                voq_count[(i*N+j)*CNT_W +: CNT_W] = CNT_W'(q[i][j]);
                voq_nonempty[i*N+j] = (q[i][j] != 0);
            end
    endtask

    task automatic model_next();
        bit kp [N];
        bit busy [N];
        int g [N];
        for (int j = 0; j < N; j++) busy[j] = 0;
        for (int i = 0; i < N; i++) begin
            kp[i] = (mv[i] != 0) && q[i][mo[i]] != 0 && !(limit_en && ms[i] >= int'(limit_val));
            if (kp[i]) busy[mo[i]] = 1;
            ngp[i] = gp[i]; nap[i] = ap[i];
        end
        for (int j = 0; j < N; j++) begin
            g[j] = -1;
            for (int k = 0; k < N; k++) begin
                int i = (gp[j] + k) % N;
                if (g[j] < 0 && !kp[i] && !busy[j] && q[i][j] > 0) g[j] = i;
            end
        end
        for (int i = 0; i < N; i++) begin
            int a = -1;
            if (kp[i]) begin
                nv[i] = 1; no[i] = mo[i]; ns[i] = (ms[i] >= 15) ? 15 : ms[i] + 1;
                continue;
            end
            for (int k = 0; k < N; k++) begin
                int j = (ap[i] + k) % N;
                if (a < 0 && g[j] == i) a = j;
            end
            if (a >= 0) begin
                nv[i] = 1; no[i] = a; ns[i] = 1;
                nap[i] = (a + 1) % N; ngp[a] = (i + 1) % N;
            end else begin
                nv[i] = 0; no[i] = 0; ns[i] = 0;
            end
        end
    endtask

    task automatic slot(input string tag);
        serve_and_arrive();
        drive();
        model_next();
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            mv[i] = nv[i]; mo[i] = no[i]; ms[i] = ns[i]; gp[i] = ngp[i]; ap[i] = nap[i];
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mo[i] = 0; ms[i] = 0; gp[i] = 0; ap[i] = 0;
            for (int j = 0; j < N; j++) q[i][j] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(match_vld == '0, "R1 reset idle", int'(match_vld), 0);
        rst_n = 1'b1;

        // Directed contention: R3 R4 R5 R7 R11
        q[0][0] = 1; q[0][1] = 1; q[1][0] = 1; q[1][1] = 1;
        slot("R3 R5 R11 contention");
        check(match_vld == 4'b0001, "R1 R3 first slot vld", int'(match_vld), 1);
        check(match_out[1:0] == 2'd0, "R5 first slot out", int'(match_out[1:0]), 0);
        slot("R4 R7 second slot");
        check(match_vld == 4'b0011, "R4 R7 second slot vld", int'(match_vld), 3);
        check(match_out[1:0] == 2'd1, "R4 in0 out", int'(match_out[1:0]), 1);
        check(match_out[3:2] == 2'd0, "R4 in1 out", int'(match_out[3:2]), 0);
        repeat (3) slot("R7 drain");

        // Long queue hold: R6 R10
        q[2][3] = 5; q[3][3] = 2; q[3][1] = 1;
        repeat (10) slot("R6 R10 hold");

        mode = 1;
        repeat (400) slot("R2 R6 R9 uniform exhaustive");
        limit_en = 1'b1; limit_val = 4'd3;
        repeat (400) slot("R8 R9 uniform limited");
        limit_en = 1'b0; mode = 2;
        repeat (400) slot("R3 R5 diagonal");
        mode = 3; limit_en = 1'b1; limit_val = 4'd2;
        repeat (400) slot("R8 R10 hotspot limited");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule